// File: doc/BRIEF.md
# SPI EEPROM Boot Stream Loader

This block runs by itself out of reset as an SPI master toward a serial EEPROM. It pulls a boot image from the EEPROM in one unbroken read burst and unpacks that image into local memory. It first selects the EEPROM and issues a read command and a start address. From then on it clocks in bytes, with MOSI held at zero, and interprets them as a stream.

Two adjacent bytes form one 16-bit word, and the low byte arrives first. The stream carries these fields in order:

- a key word that guards the load;
- one byte for a clock prescaler and one byte for a baud divider, both of which retime the rest of the burst;
- a fixed run of reserved words, which are thrown away;
- a 32-bit entry point;
- any number of blocks, each made of a size word, a 32-bit destination and that many data words.

A block whose size is zero ends the load. If the key is wrong, the load is abandoned and a fixed fallback entry address is reported instead.

The control is a single state machine. Its states are:

- `ST_IDLE`: one cycle after reset.
- `ST_CMD`, `ST_AHI`, `ST_ALO`: the command byte, then the address high and low bytes.
- `ST_KEY`: the key word.
- `ST_PRESC`, `ST_BAUD`: the two timing bytes.
- `ST_RSVD`: the reserved words.
- `ST_ENTRY`: the entry point.
- `ST_SIZE`: a block size word.
- `ST_DEST`: a block destination.
- `ST_DATA`: the block payload.
- `ST_DONE`, `ST_ABORT`: the two terminal states.

Its transitions are:

- `ST_IDLE` goes to `ST_CMD`.
- The byte states `ST_CMD`, `ST_AHI`, `ST_ALO`, `ST_PRESC` and `ST_BAUD` each advance after one byte.
- `ST_KEY` goes to `ST_PRESC` on a match and to `ST_ABORT` otherwise.
- `ST_RSVD` advances after the last reserved word, and `ST_ENTRY` after its second word.
- `ST_SIZE` goes to `ST_DONE` on a zero size and to `ST_DEST` otherwise.
- `ST_DEST` goes to `ST_DATA` after two words.
- `ST_DATA` returns to `ST_SIZE` after the last word of the block.

Top module: `spi_boot_loader`

## Requirements
- R1: Chip select (`spi_cs_n`, active low) goes low one cycle after reset and stays low for the whole load. It is released exactly once, when the load finishes or aborts. After that no further SCLK edge appears until the next reset.
- R2: Every transfer is 8 bits, sent MSB first. SCLK idles low, MISO is sampled on the rising edge, and MOSI changes only on falling edges. From the fourth byte onward every byte sent on MOSI is 0x00.
- R3: The first three bytes sent on MOSI are the read command 0x03, then the start address 0x0000 as its high byte and then its low byte.
- R4: Each SCLK half period lasts (P+1)*(D+1) clock cycles, where P is the prescaler and D is the divider. After reset P=0 and D=0x7F, so a half period is 128 cycles.
- R5: A word is two bytes with the low byte received first. If the first word is not 0x08AA, `boot_abort` is set, `entry_addr` becomes 0x003F7FF6 and no memory write happens.
- R6: The byte after the key is the new prescaler and the byte after that is the new divider. Both appear on `clk_presc` and `baud_div` and set the timing of every later transfer.
- R7: The seven words after the divider byte are discarded and cause no memory write.
- R8: The next two words are the entry point, upper half first.
- R9: Each block is a size word N, then a destination as two words (upper half first), then N data words. Data word k is written once, with a one-cycle `mem_we` pulse, to destination+k.
- R10: A size word of 0 ends the load. `boot_done` is then set with `entry_addr` equal to the captured entry point, and both `boot_done` and `boot_abort` hold until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, restarts the load |
| spi_miso | input | 1 | Serial data from the EEPROM |
| spi_sclk | output | 1 | SPI clock, idles low |
| spi_mosi | output | 1 | Serial data to the EEPROM |
| spi_cs_n | output | 1 | EEPROM select, active low |
| mem_we | output | 1 | One-cycle memory write strobe |
| mem_addr | output | 32 | Memory write address |
| mem_wdata | output | 16 | Memory write data |
| clk_presc | output | 8 | Prescaler value in use |
| baud_div | output | 8 | Baud divider value in use |
| boot_done | output | 1 | Load completed |
| boot_abort | output | 1 | Load abandoned on key mismatch |
| entry_addr | output | 32 | Entry point, or the fallback address after an abort |

## Verification
Some properties are checked by assertions on every cycle:

- SCLK is low whenever the shift engine is idle, and a transfer is only started on an idle engine.
- Done and abort never coincide, and once set they stay set with chip select released.
- An abort can only follow the key state, and it carries the fallback address.
- Memory writes occur only while the EEPROM is selected.

Other behaviour needs the bench scenarios, because it depends on the contents of the image:

- the exact command and address bytes;
- the half-period lengths before and after the timing bytes;
- the byte order of words and long words;
- the discarding of the reserved words;
- the address sequence of the writes, including across a 16-bit carry.

// File: rtl/spi_boot_pkg.sv
package spi_boot_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;
    localparam int ADDR_W = 32;

    typedef enum logic [3:0] {
        ST_IDLE, ST_CMD, ST_AHI, ST_ALO, ST_KEY, ST_PRESC, ST_BAUD,
        ST_RSVD, ST_ENTRY, ST_SIZE, ST_DEST, ST_DATA, ST_DONE, ST_ABORT
    } ldr_state_e;
endpackage

// File: rtl/spi_byte_xfer.sv
module spi_byte_xfer
    import spi_boot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic [BYTE_W-1:0] presc,
    input  logic [BYTE_W-1:0] div,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              busy,
    output logic              done,
    output logic [BYTE_W-1:0] rx_byte
);
    localparam int BIT_CW = $clog2(BYTE_W);

    logic [BYTE_W-1:0] tx_sh;
    logic [BYTE_W-1:0] pcnt;
    logic [BYTE_W-1:0] hcnt;
    logic [BIT_CW-1:0] bitn;

    assign mosi = tx_sh[BYTE_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            sclk    <= 1'b0;
            tx_sh   <= '0;
            rx_byte <= '0;
            pcnt    <= '0;
            hcnt    <= '0;
            bitn    <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy  <= 1'b1;
                    tx_sh <= tx_byte;
                    pcnt  <= '0;
                    hcnt  <= '0;
                    bitn  <= '0;
                end
            end else if (pcnt == presc) begin
                pcnt <= '0;
                if (hcnt == div) begin
                    hcnt <= '0;
                    if (!sclk) begin
                        sclk    <= 1'b1;
                        rx_byte <= {rx_byte[BYTE_W-2:0], miso};
                    end else begin
                        sclk <= 1'b0;
                        if (bitn == BIT_CW'(BYTE_W-1)) begin
                            busy <= 1'b0;
                            done <= 1'b1;
                        end else begin
                            bitn  <= bitn + 1'b1;
                            tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                        end
                    end
                end else begin
                    hcnt <= hcnt + 1'b1;
                end
            end else begin
                pcnt <= pcnt + 1'b1;
            end
        end
    end

    // R2: clock rests low between characters
    p_sclk_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);

    // R1: a new character is only launched on an idle engine
    p_start_when_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
endmodule

// File: rtl/boot_parser.sv
module boot_parser
    import spi_boot_pkg::*;
#(
    parameter logic [BYTE_W-1:0] READ_CMD   = 8'h03,
    parameter logic [WORD_W-1:0] START_ADDR = 16'h0000,
    parameter logic [WORD_W-1:0] KEY_WORD   = 16'h08AA,
    parameter logic [ADDR_W-1:0] FALLBACK   = 32'h003F_7FF6,
    parameter logic [BYTE_W-1:0] RST_PRESC  = 8'h00,
    parameter logic [BYTE_W-1:0] RST_DIV    = 8'h7F,
    parameter int                RSVD_WORDS = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              xfer_start,
    output logic [BYTE_W-1:0] xfer_tx,
    input  logic              xfer_done,
    input  logic [BYTE_W-1:0] xfer_rx,
    output logic              cs_n,
    output logic [BYTE_W-1:0] presc_q,
    output logic [BYTE_W-1:0] div_q,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              done,
    output logic              abort,
    output logic [ADDR_W-1:0] entry_addr
);
    localparam int WCW = $clog2(RSVD_WORDS + 2);

    ldr_state_e        state, nxt;
    logic              pend, hi_ph, running, word_st, word_rdy;
    logic [BYTE_W-1:0] lo_b;
    logic [WORD_W-1:0] word, rem;
    logic [WCW-1:0]    wcnt;
    logic [ADDR_W-1:0] dst, entry;

    assign running  = !(state inside {ST_IDLE, ST_DONE, ST_ABORT});
    assign word_st  = state inside {ST_KEY, ST_RSVD, ST_ENTRY, ST_SIZE, ST_DEST, ST_DATA};
    assign word     = {xfer_rx, lo_b};
    assign word_rdy = xfer_done && hi_ph;
    assign cs_n       = !running;
    assign xfer_start = running && !pend;

    always_comb begin
        unique case (state)
            ST_CMD:  xfer_tx = READ_CMD;
            ST_AHI:  xfer_tx = START_ADDR[WORD_W-1:BYTE_W];
            ST_ALO:  xfer_tx = START_ADDR[BYTE_W-1:0];
            default: xfer_tx = '0;
        endcase
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  nxt = ST_CMD;
            ST_CMD:   if (xfer_done) nxt = ST_AHI;
            ST_AHI:   if (xfer_done) nxt = ST_ALO;
            ST_ALO:   if (xfer_done) nxt = ST_KEY;
            ST_KEY:   if (word_rdy) nxt = (word == KEY_WORD) ? ST_PRESC : ST_ABORT;
            ST_PRESC: if (xfer_done) nxt = ST_BAUD;
            ST_BAUD:  if (xfer_done) nxt = ST_RSVD;
            ST_RSVD:  if (word_rdy && wcnt == WCW'(RSVD_WORDS - 1)) nxt = ST_ENTRY;
            ST_ENTRY: if (word_rdy && wcnt == WCW'(1)) nxt = ST_SIZE;
            ST_SIZE:  if (word_rdy) nxt = (word == '0) ? ST_DONE : ST_DEST;
            ST_DEST:  if (word_rdy && wcnt == WCW'(1)) nxt = ST_DATA;
            ST_DATA:  if (word_rdy && rem == WORD_W'(1)) nxt = ST_SIZE;
            ST_DONE:  nxt = ST_DONE;
            ST_ABORT: nxt = ST_ABORT;
            default:  nxt = ST_ABORT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend       <= 1'b0;
            hi_ph      <= 1'b0;
            lo_b       <= '0;
            wcnt       <= '0;
            rem        <= '0;
            dst        <= '0;
            entry      <= '0;
            presc_q    <= RST_PRESC;
            div_q      <= RST_DIV;
            mem_we     <= 1'b0;
            mem_addr   <= '0;
            mem_wdata  <= '0;
            done       <= 1'b0;
            abort      <= 1'b0;
            entry_addr <= '0;
        end else begin
            mem_we <= 1'b0;
            if (xfer_start)     pend <= 1'b1;
            else if (xfer_done) pend <= 1'b0;
            if (xfer_done && word_st) begin
                hi_ph <= !hi_ph;
                if (!hi_ph) lo_b <= xfer_rx;
            end
            if (word_rdy) wcnt <= (nxt != state) ? '0 : wcnt + 1'b1;
            if (xfer_done && state == ST_PRESC) presc_q <= xfer_rx;
            if (xfer_done && state == ST_BAUD)  div_q   <= xfer_rx;
            if (word_rdy) begin
                unique case (state)
                    ST_ENTRY: entry <= {entry[WORD_W-1:0], word};
                    ST_SIZE:  rem   <= word;
                    ST_DEST:  dst   <= {dst[WORD_W-1:0], word};
                    ST_DATA: begin
                        mem_we    <= 1'b1;
                        mem_addr  <= dst;
                        mem_wdata <= word;
                        dst       <= dst + 1'b1;
                        rem       <= rem - 1'b1;
                    end
                    default: ;
                endcase
            end
            if (nxt == ST_DONE && state != ST_DONE) begin
                done       <= 1'b1;
                entry_addr <= entry;
            end
            if (nxt == ST_ABORT && state != ST_ABORT) begin
                abort      <= 1'b1;
                entry_addr <= FALLBACK;
            end
        end
    end

    // R10: the two terminal outcomes exclude each other
    p_done_abort_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && abort));
    // R10: completion is sticky and the EEPROM stays released
    p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && cs_n));
    // R5: abort only ever follows key evaluation, with the fallback address
    p_abort_from_key_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(abort) |-> ($past(state) == ST_KEY && entry_addr == FALLBACK));
    // R9: payload writes happen only inside the selected burst
    p_write_in_burst_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !cs_n);
endmodule

// File: rtl/spi_boot_loader.sv
module spi_boot_loader
    import spi_boot_pkg::*;
#(
    parameter logic [BYTE_W-1:0] READ_CMD   = 8'h03,
    parameter logic [WORD_W-1:0] START_ADDR = 16'h0000,
    parameter logic [WORD_W-1:0] KEY_WORD   = 16'h08AA,
    parameter logic [ADDR_W-1:0] FALLBACK   = 32'h003F_7FF6,
    parameter logic [BYTE_W-1:0] RST_PRESC  = 8'h00,
    parameter logic [BYTE_W-1:0] RST_DIV    = 8'h7F,
    parameter int                RSVD_WORDS = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        spi_miso,
    output logic        spi_sclk,
    output logic        spi_mosi,
    output logic        spi_cs_n,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [15:0] mem_wdata,
    output logic [7:0]  clk_presc,
    output logic [7:0]  baud_div,
    output logic        boot_done,
    output logic        boot_abort,
    output logic [31:0] entry_addr
);
    logic              x_start, x_done, x_busy;
    logic [BYTE_W-1:0] x_tx, x_rx;

    boot_parser #(
        .READ_CMD(READ_CMD), .START_ADDR(START_ADDR), .KEY_WORD(KEY_WORD),
        .FALLBACK(FALLBACK), .RST_PRESC(RST_PRESC), .RST_DIV(RST_DIV),
        .RSVD_WORDS(RSVD_WORDS)
    ) u_parser (
        .clk(clk), .rst_n(rst_n),
        .xfer_start(x_start), .xfer_tx(x_tx), .xfer_done(x_done), .xfer_rx(x_rx),
        .cs_n(spi_cs_n), .presc_q(clk_presc), .div_q(baud_div),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .done(boot_done), .abort(boot_abort), .entry_addr(entry_addr)
    );

    spi_byte_xfer u_xfer (
        .clk(clk), .rst_n(rst_n), .start(x_start), .tx_byte(x_tx),
        .presc(clk_presc), .div(baud_div), .miso(spi_miso),
        .sclk(spi_sclk), .mosi(spi_mosi), .busy(x_busy), .done(x_done),
        .rx_byte(x_rx)
    );

    // R1: no SCLK activity while the EEPROM is deselected
    p_sclk_quiet_deselected_r1: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);
endmodule

// File: tb/spi_boot_loader_tb_top.sv
module spi_boot_loader_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_miso;
    logic        spi_sclk, spi_mosi, spi_cs_n, mem_we;
    logic [31:0] mem_addr, entry_addr;
    logic [15:0] mem_wdata;
    logic [7:0]  clk_presc, baud_div;
    logic        boot_done, boot_abort;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_boot_loader dut_i (
        .clk(clk), .rst_n(rst_n), .spi_miso(spi_miso), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .clk_presc(clk_presc),
        .baud_div(baud_div), .boot_done(boot_done), .boot_abort(boot_abort),
        .entry_addr(entry_addr)
    );

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0]  img [0:127];
    int          img_len;
    logic [31:0] exp_a [0:31];
    logic [15:0] exp_d [0:31];
    int          exp_n;
    int          wr_n;
    int          sidx, bcnt, nz_mosi, cs_rise, first_hi, last_hi, hc;
    logic [7:0]  mosi_sh;
    logic [7:0]  cap [0:255];
    logic        run_on = 1'b0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        img[img_len] = b;
        img_len++;
    endtask
    task automatic push_w(input logic [15:0] w);
        push(w[7:0]);
        push(w[15:8]);
    endtask
    task automatic push_l(input logic [31:0] l);
        push_w(l[31:16]);
        push_w(l[15:0]);
    endtask
    task automatic header(input logic [15:0] key, input logic [7:0] p, input logic [7:0] d,
                          input logic [31:0] ent);
        img_len = 0;
        exp_n = 0;
        push_w(key);
        push(p);
        push(d);
        for (int i = 0; i < 7; i++) push_w(16'h5A00 + 16'(i) * 16'h0111);
        push_l(ent);
    endtask
    task automatic block(input logic [31:0] dest, input int n, input logic [15:0] seed);
        push_w(16'(n));
        push_l(dest);
        for (int k = 0; k < n; k++) begin
            push_w(seed ^ 16'(k * 16'h1357));
            exp_a[exp_n] = dest + 32'(k);
            exp_d[exp_n] = seed ^ 16'(k * 16'h1357);
            exp_n++;
        end
    endtask

    // EEPROM model: captures MOSI and shifts the image out MSB first
    assign spi_miso = (sidx >= 3 && (sidx - 3) < img_len) ? img[sidx-3][7-bcnt] : 1'b0;

    always @(posedge spi_sclk) begin
        mosi_sh = {mosi_sh[6:0], spi_mosi};
        bcnt++;
        if (bcnt == 8) begin
            if (sidx < 256) cap[sidx] = mosi_sh;
            if (sidx >= 3 && mosi_sh != 8'h00) nz_mosi++;
            sidx++;
            bcnt = 0;
        end
    end

    always @(posedge spi_cs_n) if (run_on) cs_rise++;

    always @(negedge clk) begin
        if (run_on) begin
            if (spi_sclk) hc++;
            else if (hc > 0) begin
                if (first_hi == 0) first_hi = hc;
                last_hi = hc;
                hc = 0;
            end
            if (mem_we) begin
                if (wr_n < exp_n) begin
                    check("R9 write addr", 64'(mem_addr), 64'(exp_a[wr_n]));
                    check("R9 write data", 64'(mem_wdata), 64'(exp_d[wr_n]));
                end else begin
                    check("R7/R9 unexpected write", 64'(wr_n), 64'(exp_n - 1));
                end
                wr_n++;
            end
        end
    end

    task automatic restart();
        run_on = 1'b0;
        rst_n = 1'b0;
        sidx = 0; bcnt = 0; nz_mosi = 0; cs_rise = 0;
        first_hi = 0; last_hi = 0; hc = 0; wr_n = 0; mosi_sh = '0;
        repeat (3) @(negedge clk);
        check("R1 reset cs_n", 64'(spi_cs_n), 64'd1);
        check("R2 reset sclk", 64'(spi_sclk), 64'd0);
        check("R10 reset done/abort", 64'({boot_done, boot_abort}), 64'd0);
        check("R4 reset divider", 64'({clk_presc, baud_div}), 64'h007F);
        run_on = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 cs low after reset", 64'(spi_cs_n), 64'd0);
    endtask

    task automatic finish_run(input logic exp_done, input logic [31:0] exp_ent,
                              input logic [7:0] p, input logic [7:0] d, input int exp_hi);
        int t;
        int s0;
        t = 0;
        while (!(boot_done || boot_abort) && t < 40000) begin
            @(negedge clk);
            t++;
        end
        check("R1 load terminates", 64'(t < 40000), 64'd1);
        @(negedge clk);
        check("R10 done flag", 64'(boot_done), 64'(exp_done));
        check("R5 abort flag", 64'(boot_abort), 64'(!exp_done));
        check(exp_done ? "R8 entry point" : "R5 fallback entry", 64'(entry_addr), 64'(exp_ent));
        check("R3 read command", 64'(cap[0]), 64'h03);
        check("R3 start address", 64'({cap[1], cap[2]}), 64'h0000);
        check("R2 MOSI zero while reading", 64'(nz_mosi), 64'd0);
        check("R4 first half period", 64'(first_hi), 64'd128);
        s0 = sidx * 8 + bcnt;
        repeat (200) @(negedge clk);
        check("R1 single release", 64'(cs_rise), 64'd1);
        check("R1 no clocks after end", 64'(sidx * 8 + bcnt), 64'(s0));
        check("R10 outcome holds", 64'({boot_done, boot_abort}), 64'({exp_done, !exp_done}));
        check("R7/R9 write count", 64'(wr_n), 64'(exp_n));
        if (exp_done) begin
            check("R6 prescaler/divider", 64'({clk_presc, baud_div}), 64'({p, d}));
            check("R6 retimed half period", 64'(last_hi), 64'(exp_hi));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // Two blocks, second crosses a 16-bit address carry: R6 R8 R9 R10
        header(16'h08AA, 8'd1, 8'd2, 32'h1234_5678);
        block(32'h0000_1000, 3, 16'hBEEF);
        block(32'h0002_FFFF, 2, 16'hA5A5);
        push_w(16'h0000);
        restart();
        finish_run(1'b1, 32'h1234_5678, 8'd1, 8'd2, 6);

        // Key bytes in swapped order must abort: R5
        header(16'hAA08, 8'd0, 8'd0, 32'h0);
        exp_n = 0;
        restart();
        finish_run(1'b0, 32'h003F_7FF6, 8'd0, 8'd0, 0);

        // Fastest timing, single block: R4 R6 R9
        header(16'h08AA, 8'd0, 8'd0, 32'h8000_0001);
        block(32'h0000_0010, 4, 16'h0F0F);
        push_w(16'h0000);
        restart();
        finish_run(1'b1, 32'h8000_0001, 8'd0, 8'd0, 1);

        // Immediate zero-size block: R7 R10
        header(16'h08AA, 8'd3, 8'd0, 32'hCAFE_F00D);
        push_w(16'h0000);
        restart();
        finish_run(1'b1, 32'hCAFE_F00D, 8'd3, 8'd0, 4);

        // Near-miss key: R5
        header(16'h08AB, 8'd0, 8'd0, 32'h0);
        exp_n = 0;
        restart();
        finish_run(1'b0, 32'h003F_7FF6, 8'd0, 8'd0, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule